// File: doc/BRIEF.md
# Coherent Cache Request Adapter

This block sits between a small byte-addressed L1 data cache and one port of a coherent interconnect. The cache hands it a single command at a time: a 3-bit command code, a dirty qualifier, a 32-bit address and one full line of write data, all framed by a valid flag. The adapter turns that command into one simplified coherent transaction. It drives a request with an opcode, a line-aligned address and optional line data, then waits for a response. When the response arrives, it returns the fill data and the line attributes the cache should install. A one-cycle ready pulse tells the cache that the transaction is complete.

The adapter decides which coherence opcode each command needs. A read miss becomes a shared read and a write miss becomes a unique read. A write hit on a shared line becomes an in-place upgrade, during which the cache stalls with ready low. A replaced line becomes either a data-less eviction or a full writeback, chosen by the dirty qualifier.

Both sides use valid/ready handshakes. Once the cache raises `cmd_valid_i`, it must hold the command stable until it sees `cmd_rdy_o`. The adapter holds `req_valid_o` and every request field stable until the interconnect accepts the request with `req_ready_i`. The adapter raises `rsp_ready_o` only while it waits for a response, and it takes the response in the same cycle that `rsp_valid_i` is high. Only one transaction is ever in flight.

Top module: `coh_req_adapter`

## Requirements
- R1: After a synchronous active-high reset, `req_valid_o`, `rsp_ready_o`, `cmd_rdy_o` and `err_o` are 0, and every data and opcode output is 0.
- R2: Command code 1 (read shared) issues request opcode 1 (shared read) with `req_has_data_o`=0. Its completion reports `fill_shared_o`=1 and `fill_dirty_o`=0.
- R3: Command code 2 (read unique) issues request opcode 2 (unique read) with no data. Its completion reports `fill_shared_o`=0 and `fill_dirty_o`=1.
- R4: Command code 4 (clean unique) issues request opcode 3 (upgrade) with no data. `cmd_rdy_o` stays 0 until the response has been accepted. The completion reports `fill_shared_o`=0 and `fill_dirty_o`=1.
- R5: Command code 3 (write) with `cmd_dirty_i`=1 issues opcode 5 (full writeback) with `req_has_data_o`=1 and `req_data_o` equal to the command line. With `cmd_dirty_i`=0 it issues opcode 4 (evict) with `req_has_data_o`=0 and `req_data_o`=0. Both completions report shared=0 and dirty=0.
- R6: `req_addr_o` is the command address with its low log2(LINE_BYTES) bits cleared. While `req_valid_o` is high and `req_ready_i` is low, the request fields do not change. When `req_valid_o` is low, opcode, address and data outputs read 0.
- R7: `rsp_ready_o` is high only while a response is awaited. A response is accepted in the cycle where `rsp_valid_i` and `rsp_ready_o` are both high. `fill_data_o` then shows that response's data during the following `cmd_rdy_o` cycle.
- R8: `cmd_rdy_o` is a one-cycle pulse. It is asserted in the cycle after the response is accepted, or in the cycle after the command is taken when no request is needed.
- R9: Only one transaction is outstanding at a time. Changes on the command inputs while a transaction is in progress have no effect on the request, the completion or `err_o`.
- R10: Command code 0 (none) issues no request and completes with a `cmd_rdy_o` pulse one cycle after it is taken. The fill outputs are 0 and `err_o` is unchanged.
- R11: Command codes 5, 6 and 7 issue no request and complete like code 0. They also set `err_o`, which then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Cache command valid, held until `cmd_rdy_o` |
| cmd_code_i | input | 3 | Cache command code (0 none, 1 read shared, 2 read unique, 3 write, 4 clean unique) |
| cmd_dirty_i | input | 1 | Dirty qualifier for the write command |
| cmd_addr_i | input | ADDR_W | Command byte address |
| cmd_wdata_i | input | LINE_BYTES*8 | Line data for a writeback |
| cmd_rdy_o | output | 1 | One-cycle completion pulse |
| fill_data_o | output | LINE_BYTES*8 | Response line, valid with `cmd_rdy_o` |
| fill_shared_o | output | 1 | Install the line as shared, valid with `cmd_rdy_o` |
| fill_dirty_o | output | 1 | Install the line as dirty, valid with `cmd_rdy_o` |
| req_valid_o | output | 1 | Interconnect request valid |
| req_ready_i | input | 1 | Interconnect request ready |
| req_op_o | output | 3 | Request opcode (1 shared read, 2 unique read, 3 upgrade, 4 evict, 5 full writeback) |
| req_addr_o | output | ADDR_W | Line-aligned request address |
| req_has_data_o | output | 1 | Request carries a line of data |
| req_data_o | output | LINE_BYTES*8 | Request line data |
| rsp_valid_i | input | 1 | Interconnect response valid |
| rsp_ready_o | output | 1 | Response ready, high only while waiting |
| rsp_data_i | input | LINE_BYTES*8 | Response line data |
| err_o | output | 1 | Sticky flag for an unused command code |

## Verification
Every cycle, the assertions check that a stalled request holds its fields, that the request, response and completion phases never overlap, and that the completion pulse comes right after an accepted response and lasts one cycle. They also check that data travels only with a full writeback, that the error flag never clears without a reset, and that outputs are quiet just after reset. The mapping from command code and dirty qualifier to opcode and install attributes, the alignment of the address, and the fill data returned from the response can only be shown by the bench. It does this by running every code under varied request and response delays against its reference model. The same holds for the immunity to command changes mid-transaction.

// File: rtl/coh_req_pkg.sv
package coh_req_pkg;

  typedef enum logic [2:0] {
    CMD_NONE         = 3'd0,
    CMD_READ_SHARED  = 3'd1,
    CMD_READ_UNIQUE  = 3'd2,
    CMD_WRITE        = 3'd3,
    CMD_CLEAN_UNIQUE = 3'd4
  } cache_cmd_e;

  typedef enum logic [2:0] {
    OP_IDLE         = 3'd0,
    OP_RD_SHARED    = 3'd1,
    OP_RD_UNIQUE    = 3'd2,
    OP_CLEAN_UNIQUE = 3'd3,
    OP_EVICT        = 3'd4,
    OP_WB_FULL      = 3'd5
  } coh_op_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_SEND_REQ = 2'd1,
    ST_WAIT_RSP = 2'd2,
    ST_DONE     = 2'd3
  } txn_state_e;

  typedef struct packed {
    logic    issue;
    logic    illegal;
    coh_op_e op;
    logic    carries_data;
    logic    fill_shared;
    logic    fill_dirty;
  } cmd_decode_t;

endpackage

// File: rtl/coh_cmd_decode.sv
module coh_cmd_decode
  import coh_req_pkg::*;
(
  input  logic [2:0]  code_i,
  input  logic        dirty_i,
  output cmd_decode_t dec_o
);

  always_comb begin
    dec_o = '0;
    case (code_i)
      CMD_NONE: begin
        dec_o.issue = 1'b0;
      end
      CMD_READ_SHARED: begin
        dec_o.issue       = 1'b1;
        dec_o.op          = OP_RD_SHARED;
        dec_o.fill_shared = 1'b1;
      end
      CMD_READ_UNIQUE: begin
        dec_o.issue      = 1'b1;
        dec_o.op         = OP_RD_UNIQUE;
        dec_o.fill_dirty = 1'b1;
      end
      CMD_WRITE: begin
        dec_o.issue        = 1'b1;
        dec_o.op           = dirty_i ? OP_WB_FULL : OP_EVICT;
        dec_o.carries_data = dirty_i;
      end
      CMD_CLEAN_UNIQUE: begin
        dec_o.issue      = 1'b1;
        dec_o.op         = OP_CLEAN_UNIQUE;
        dec_o.fill_dirty = 1'b1;
      end
      default: begin
        dec_o.illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/coh_txn_fsm.sv
module coh_txn_fsm
  import coh_req_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid_i,
  input  logic       issue_i,
  input  logic       req_ready_i,
  input  logic       rsp_valid_i,
  output logic       accept_o,
  output logic       req_valid_o,
  output logic       rsp_ready_o,
  output logic       rsp_fire_o,
  output logic       done_o
);

  txn_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (cmd_valid_i) state_d = issue_i ? ST_SEND_REQ : ST_DONE;
      ST_SEND_REQ: if (req_ready_i) state_d = ST_WAIT_RSP;
      ST_WAIT_RSP: if (rsp_valid_i) state_d = ST_DONE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign accept_o    = (state_q == ST_IDLE) && cmd_valid_i;
  assign req_valid_o = (state_q == ST_SEND_REQ);
  assign rsp_ready_o = (state_q == ST_WAIT_RSP);
  assign rsp_fire_o  = rsp_ready_o && rsp_valid_i;
  assign done_o      = (state_q == ST_DONE);

endmodule

// File: rtl/coh_txn_regs.sv
module coh_txn_regs
  import coh_req_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              rsp_fire_i,
  input  cmd_decode_t       dec_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LINE_W-1:0] wdata_i,
  input  logic [LINE_W-1:0] rsp_data_i,
  output coh_op_e           op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LINE_W-1:0] data_o,
  output logic              has_data_o,
  output logic              fill_shared_o,
  output logic              fill_dirty_o,
  output logic [LINE_W-1:0] fill_o,
  output logic              err_o
);

  logic [ADDR_W-1:0] aligned;
  assign aligned = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      op_o          <= OP_IDLE;
      addr_o        <= '0;
      data_o        <= '0;
      has_data_o    <= 1'b0;
      fill_shared_o <= 1'b0;
      fill_dirty_o  <= 1'b0;
      fill_o        <= '0;
      err_o         <= 1'b0;
    end else if (accept_i) begin
      op_o          <= dec_i.op;
      addr_o        <= dec_i.issue ? aligned : '0;
      data_o        <= dec_i.carries_data ? wdata_i : '0;
      has_data_o    <= dec_i.carries_data;
      fill_shared_o <= dec_i.fill_shared;
      fill_dirty_o  <= dec_i.fill_dirty;
      fill_o        <= '0;
      if (dec_i.illegal) err_o <= 1'b1;
    end else if (rsp_fire_i) begin
      fill_o <= rsp_data_i;
    end
  end

endmodule

// File: rtl/coh_req_adapter.sv
module coh_req_adapter
  import coh_req_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_code_i,
  input  logic              cmd_dirty_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LINE_W-1:0] cmd_wdata_i,
  output logic              cmd_rdy_o,
  output logic [LINE_W-1:0] fill_data_o,
  output logic              fill_shared_o,
  output logic              fill_dirty_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [2:0]        req_op_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              req_has_data_o,
  output logic [LINE_W-1:0] req_data_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [LINE_W-1:0] rsp_data_i,
  output logic              err_o
);

  cmd_decode_t       dec;
  logic              accept, rsp_fire, done, req_vld;
  coh_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] data_q, fill_q;
  logic              has_data_q, shared_q, dirty_q;

  coh_cmd_decode u_dec (
    .code_i  (cmd_code_i),
    .dirty_i (cmd_dirty_i),
    .dec_o   (dec)
  );

  coh_txn_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .issue_i     (dec.issue),
    .req_ready_i (req_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .accept_o    (accept),
    .req_valid_o (req_vld),
    .rsp_ready_o (rsp_ready_o),
    .rsp_fire_o  (rsp_fire),
    .done_o      (done)
  );

  coh_txn_regs #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .OFF_W  (OFF_W)
  ) u_regs (
    .clk           (clk),
    .rst           (rst),
    .accept_i      (accept),
    .rsp_fire_i    (rsp_fire),
    .dec_i         (dec),
    .addr_i        (cmd_addr_i),
    .wdata_i       (cmd_wdata_i),
    .rsp_data_i    (rsp_data_i),
    .op_o          (op_q),
    .addr_o        (addr_q),
    .data_o        (data_q),
    .has_data_o    (has_data_q),
    .fill_shared_o (shared_q),
    .fill_dirty_o  (dirty_q),
    .fill_o        (fill_q),
    .err_o         (err_o)
  );

  assign req_valid_o    = req_vld;
  assign req_op_o       = req_vld ? op_q   : OP_IDLE;
  assign req_addr_o     = req_vld ? addr_q : '0;
  assign req_data_o     = req_vld ? data_q : '0;
  assign req_has_data_o = req_vld & has_data_q;

  assign cmd_rdy_o      = done;
  assign fill_data_o    = done ? fill_q : '0;
  assign fill_shared_o  = done & shared_q;
  assign fill_dirty_o   = done & dirty_q;

endmodule

// File: rtl/coh_req_adapter_chk.sv
module coh_req_adapter_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_rdy_o,
  input logic              fill_shared_o,
  input logic              fill_dirty_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [2:0]        req_op_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              req_has_data_o,
  input logic [LINE_W-1:0] req_data_o,
  input logic              rsp_valid_i,
  input logic              rsp_ready_o,
  input logic              err_o
);

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !req_valid_o && !rsp_ready_o && !cmd_rdy_o && !err_o); // R1

  AST_SHARED_FILL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    cmd_rdy_o && fill_shared_o |-> !fill_dirty_o); // R2

  AST_READS_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    req_valid_o && (req_op_o inside {3'd1, 3'd2, 3'd3}) |-> !req_has_data_o); // R3

  AST_DATA_ONLY_WB: assert property (@(posedge clk) disable iff (rst)
    req_valid_o && req_has_data_o |-> req_op_o == 3'd5); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_op_o) &&
      $stable(req_addr_o) && $stable(req_data_o)); // R6

  AST_RDY_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_i && rsp_ready_o |=> cmd_rdy_o); // R7

  AST_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_rdy_o |=> !cmd_rdy_o); // R8

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_valid_o, rsp_ready_o, cmd_rdy_o})); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o); // R11

endmodule

bind coh_req_adapter coh_req_adapter_chk #(
  .ADDR_W (ADDR_W),
  .LINE_W (LINE_BYTES * 8)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cmd_rdy_o      (cmd_rdy_o),
  .fill_shared_o  (fill_shared_o),
  .fill_dirty_o   (fill_dirty_o),
  .req_valid_o    (req_valid_o),
  .req_ready_i    (req_ready_i),
  .req_op_o       (req_op_o),
  .req_addr_o     (req_addr_o),
  .req_has_data_o (req_has_data_o),
  .req_data_o     (req_data_o),
  .rsp_valid_i    (rsp_valid_i),
  .rsp_ready_o    (rsp_ready_o),
  .err_o          (err_o)
);

// File: tb/coh_req_adapter_bench.sv
`timescale 1ns/1ps
module coh_req_adapter_bench;
  localparam int AW = 32;
  localparam int LB = 16;
  localparam int LW = LB * 8;
  localparam int OW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_code = '0;
  logic          cmd_dirty = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_wdata = '0;
  logic          req_ready = 1'b0;
  logic          rsp_valid = 1'b0;
  logic [LW-1:0] rsp_data = '0;

  logic          cmd_rdy, fill_shared, fill_dirty, req_valid, req_has_data, rsp_ready, err;
  logic [LW-1:0] fill_data, req_data;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;

  coh_req_adapter #(.ADDR_W(AW), .LINE_BYTES(LB)) u_coh_req_adapter (
    .clk(clk), .rst(rst),
    .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code), .cmd_dirty_i(cmd_dirty),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .cmd_rdy_o(cmd_rdy), .fill_data_o(fill_data), .fill_shared_o(fill_shared),
    .fill_dirty_o(fill_dirty),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_op_o(req_op),
    .req_addr_o(req_addr), .req_has_data_o(req_has_data), .req_data_o(req_data),
    .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready), .rsp_data_i(rsp_data),
    .err_o(err)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [LW-1:0] act,
                     input logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // Reference model: phase 0 idle, 1 request, 2 response, 3 completion
  int            m_phase = 0;
  logic [2:0]    m_op = '0;
  logic [AW-1:0] m_addr = '0;
  logic [LW-1:0] m_data = '0;
  logic          m_hasd = 1'b0, m_sh = 1'b0, m_dy = 1'b0, m_err = 1'b0;
  logic [LW-1:0] m_fill = '0;
  string         m_tag = "R10";

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_op = '0; m_addr = '0; m_data = '0;
      m_hasd = 0; m_sh = 0; m_dy = 0; m_err = 0; m_fill = '0; m_tag = "R10";
    end else if (m_phase == 0) begin
      if (cmd_valid) begin
        m_op = '0; m_addr = '0; m_data = '0; m_hasd = 0; m_sh = 0; m_dy = 0;
        m_fill = '0; m_phase = 1;
        if (cmd_code == 3'd1) begin m_op = 3'd1; m_sh = 1; m_tag = "R2"; end
        else if (cmd_code == 3'd2) begin m_op = 3'd2; m_dy = 1; m_tag = "R3"; end
        else if (cmd_code == 3'd4) begin m_op = 3'd3; m_dy = 1; m_tag = "R4"; end
        else if (cmd_code == 3'd3) begin
          m_tag = "R5";
          if (cmd_dirty) begin m_op = 3'd5; m_hasd = 1; m_data = cmd_wdata; end
          else m_op = 3'd4;
        end else begin
          m_phase = 3;
          m_tag = (cmd_code == 3'd0) ? "R10" : "R11";
          if (cmd_code != 3'd0) m_err = 1;
        end
        if (m_phase == 1) m_addr = cmd_addr & ~((32'd1 << OW) - 32'd1);
      end
    end else if (m_phase == 1) begin
      if (req_ready) m_phase = 2;
    end else if (m_phase == 2) begin
      if (rsp_valid) begin m_fill = rsp_data; m_phase = 3; end
    end else begin
      m_phase = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(req_valid == (m_phase == 1), "R6 req_valid", LW'(req_valid), LW'(m_phase == 1));
      chk(rsp_ready == (m_phase == 2), "R7 rsp_ready", LW'(rsp_ready), LW'(m_phase == 2));
      chk(cmd_rdy == (m_phase == 3), "R8 cmd_rdy", LW'(cmd_rdy), LW'(m_phase == 3));
      chk(err == m_err, "R11 err", LW'(err), LW'(m_err));
      if (m_phase == 1) begin
        chk(req_op == m_op, {m_tag, " opcode"}, LW'(req_op), LW'(m_op));
        chk(req_addr == m_addr, "R6 address", LW'(req_addr), LW'(m_addr));
        chk(req_has_data == m_hasd, "R5 has_data", LW'(req_has_data), LW'(m_hasd));
        chk(req_data == m_data, "R5 data", req_data, m_data);
      end else begin
        chk(req_op == 0 && req_addr == 0 && req_data == 0, "R6 idle fields",
            LW'(req_op), '0);
      end
      if (m_phase == 3) begin
        chk(fill_data == m_fill, "R7 fill data", fill_data, m_fill);
        chk(fill_shared == m_sh, {m_tag, " fill shared"}, LW'(fill_shared), LW'(m_sh));
        chk(fill_dirty == m_dy, {m_tag, " fill dirty"}, LW'(fill_dirty), LW'(m_dy));
      end
    end
  end

  function automatic logic [LW-1:0] rnd_line();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  int last_reqs;
  int last_lat;

  task automatic do_cmd(input logic [2:0] code, input logic dirty, input logic [AW-1:0] addr,
                        input int rqd, input int rsd, input bit tamper);
    int rc;
    int sc;
    rc = 0; sc = 0; last_reqs = 0; last_lat = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_code = code; cmd_dirty = dirty; cmd_addr = addr;
    cmd_wdata = rnd_line(); rsp_data = rnd_line();
    forever begin
      @(negedge clk);
      last_lat++;
      if (cmd_rdy) begin
        cmd_valid = 0; req_ready = 0; rsp_valid = 0;
        break;
      end
      if (req_valid) begin
        last_reqs++;
        req_ready = (rc >= rqd);
        rc++;
        if (tamper) begin cmd_code = 3'd7; cmd_addr = ~addr; cmd_wdata = rnd_line(); end
      end else req_ready = 0;
      if (rsp_ready) begin
        rsp_valid = (sc >= rsd);
        sc++;
      end else rsp_valid = 0;
    end
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    chk(!req_valid && !rsp_ready && !cmd_rdy && !err && req_op == 0 && fill_data == 0,
        "R1 reset outputs", LW'({req_valid, rsp_ready, cmd_rdy, err}), '0);
    rst = 0;
    do_cmd(3'd1, 0, 32'h1234_5678, 0, 0, 0);                   // R2
    do_cmd(3'd2, 0, 32'hDEAD_BEEF, 3, 1, 0);                   // R3
    do_cmd(3'd4, 0, 32'h0000_0F0F, 1, 5, 0);                   // R4 long stall
    chk(last_lat == 9, "R4 stall length", LW'(last_lat), LW'(9));
    do_cmd(3'd3, 1, 32'h8000_0011, 2, 0, 0);                   // R5 writeback
    do_cmd(3'd3, 0, 32'h8000_0022, 0, 2, 0);                   // R5 evict
    do_cmd(3'd0, 0, 32'hFFFF_FFFF, 0, 0, 0);
    chk(last_reqs == 0 && last_lat == 1, "R10 no request", LW'(last_reqs), '0);
    chk(err == 0, "R10 err untouched", LW'(err), '0);
    do_cmd(3'd1, 0, 32'h4444_4444, 2, 2, 1);                   // R9 tamper while busy
    chk(err == 0, "R9 busy inputs ignored", LW'(err), '0);
    do_cmd(3'd6, 1, 32'h1, 0, 0, 0);
    chk(last_reqs == 0, "R11 no request", LW'(last_reqs), '0);
    chk(err == 1, "R11 err set", LW'(err), LW'(1));
    do_cmd(3'd2, 0, 32'h2, 0, 0, 0);
    chk(err == 1, "R11 err sticky", LW'(err), LW'(1));
    for (int i = 0; i < 200; i++) begin
      do_cmd(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), $urandom,
             $urandom_range(0, 4), $urandom_range(0, 4), 0);
    end
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk);
    chk(!req_valid && !rsp_ready && !cmd_rdy && !err, "R1 reset clears",
        LW'({req_valid, rsp_ready, cmd_rdy, err}), '0);
    rst = 0;
    do_cmd(3'd5, 0, 32'h3, 0, 0, 0);
    chk(err == 1, "R11 code 5", LW'(err), LW'(1));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog: actual hung expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule